// File: doc/BRIEF.md
# NOR Flash Sector Erase Sequencer

This block drives the erase of a run of whole sectors in an 8-bit parallel NOR flash with a single fixed sector size. A request gives a byte start address and a byte length. The block first checks that the range is sector aligned, non-empty and inside the device. If the check fails, it answers at once. If it passes, the block writes the six-byte unlock and erase-setup sequence. It then issues either one whole-device command or a burst of per-sector commands.

Per-sector commands are issued three cycles apart. After each one the block reads the device status, to confirm that the command acceptance window is still open. The block then polls the device until the data-polling and toggle bits report completion, under a time budget that scales with the number of sectors. After a successful erase it reads 128 evenly spaced bytes of the range, from the top down, and each must be 0xFF. The block reports one of seven status codes with a single-cycle done pulse.

The flash bus is a simple synchronous port: a write is one cycle with `fl_req` and `fl_we` high. A read is one cycle with `fl_req` high and `fl_we` low, and its byte appears on `fl_rdata` in the following cycle. Timing budgets come from the clock-frequency parameter.

Top module: `nor_erase_seq`

## Requirements
- R1: A request with a start or length that is not a multiple of the sector size, a zero length, or start plus length beyond the device size gives `done` with status 1 (bad argument) in the cycle after `go`, and no bus write.
- R2: An accepted request first writes, in this order: 0xF0@0x555, 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA. No bus access happens while idle.
- R3: When the start is 0 and the length equals the device size, the single command that follows the setup is 0x10@0x555, and one polling pass at address 0 covers the whole device.
- R4: Otherwise 0x30 is written to the base address of each sector in the range, in ascending order. Successive sector commands are at most 3 cycles apart, which is below the acceptance window of 50 us at the clock frequency.
- R5: If bit 3 of the status read that follows a sector command is set, the run ends with status 2 (window closed) and no further command is issued.
- R6: A sector (or, for a whole-device erase, the device) counts as erased once three status reads have been taken and the latest has bit 7 high. A full run that passes verification ends with status 0.
- R7: If bit 7 of the latest read is low and that read equals the previous read, the run fails. The status is 4 (device fault) when bit 5 of the read before those two is set, and 5 (stalled) when it is clear.
- R8: When the polling time exceeds the number of requested sectors multiplied by the per-sector budget in milliseconds, the run ends with status 3 (timeout).
- R9: Verification reads the addresses start+len-1-k*(len/128) for k = 0..127, in that order. Any byte other than 0xFF ends the run with status 6 (verify error). Bytes at addresses that are not sampled have no effect.
- R10: `busy` is high from the cycle after an accepted `go` until `done`. `done` is a one-cycle pulse with `busy` low. A `go` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Request strobe, taken only when idle |
| start_addr | input | AW | Byte start address of the range |
| len_bytes | input | AW+1 | Byte length of the range |
| busy | output | 1 | Erase run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| status | output | 3 | Result code, valid with done |
| fl_req | output | 1 | Flash bus access this cycle |
| fl_we | output | 1 | Access is a write |
| fl_addr | output | AW | Flash byte address |
| fl_wdata | output | 8 | Write byte |
| fl_rdata | input | 8 | Read byte, valid the cycle after a read access |

## Verification
A rejected request must show `done` exactly one cycle after the `go` edge, so the bench samples at the next falling edge and nowhere else. A scoreboard holds the expected bus writes for each request. It is compared write by write as they appear, and the spacing between sector commands is measured in cycles at the same time. Polling and verification take a data-dependent number of cycles, so for accepted runs the bench waits for the single `done` pulse, then compares the status and checks that the queue has drained. The checker confirms that a window abort follows a status byte with bit 3 set by one cycle, and that a success follows a 0xFF read by one cycle.

// File: rtl/ners_pkg.sv
package ners_pkg;

   typedef enum logic [2:0] {
      ES_OK        = 3'd0,
      ES_BADARG    = 3'd1,
      ES_WINDOW    = 3'd2,
      ES_TIMEOUT   = 3'd3,
      ES_DEVFAULT  = 3'd4,
      ES_STALLED   = 3'd5,
      ES_BADVERIFY = 3'd6
   } ers_stat_e;

   localparam int          SETUP_LEN = 6;
   localparam logic [7:0]  CMD_CHIP  = 8'h10;
   localparam logic [7:0]  CMD_SECT  = 8'h30;
   localparam logic [7:0]  ERASED    = 8'hFF;
   localparam logic [11:0] CMD_ADDR  = 12'h555;

   // Unlock / erase-setup sequence, step by step
   function automatic logic [11:0] setup_addr(input logic [2:0] i);
      case (i)
         3'd2, 3'd5: setup_addr = 12'h2AA;
         default:    setup_addr = 12'h555;
      endcase
   endfunction

   function automatic logic [7:0] setup_data(input logic [2:0] i);
      case (i)
         3'd0:       setup_data = 8'hF0;
         3'd1, 3'd4: setup_data = 8'hAA;
         3'd2, 3'd5: setup_data = 8'h55;
         default:    setup_data = 8'h80;
      endcase
   endfunction

endpackage

// File: rtl/ners_argchk.sv
module ners_argchk #(
   parameter int AW        = 21,
   parameter int SECT_LG   = 16,
   parameter int DEV_BYTES = 2097152
) (
   input  logic [AW-1:0] start,
   input  logic [AW:0]   len,
   output logic          ok,
   output logic          chip
);
   logic [AW+1:0] end_pos;

   assign end_pos = {2'b00, start} + {1'b0, len};

   assign ok = (start[SECT_LG-1:0] == '0) && (len[SECT_LG-1:0] == '0) &&
               (len != '0) && (end_pos <= (AW+2)'(DEV_BYTES));

   assign chip = ok && (start == '0) && (len == (AW+1)'(DEV_BYTES));
endmodule

// File: rtl/ners_timer.sv
module ners_timer #(
   parameter int CYC_PER_MS = 50000,
   parameter int MSW        = 20
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic           run,
   input  logic [MSW-1:0] limit,
   output logic           expired
);
   localparam int PW = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;

   logic           tick;
   logic [MSW-1:0] ms_q;

   generate
      if (CYC_PER_MS == 1) begin : g_direct
         assign tick = run;
      end else begin : g_pre
         logic [PW-1:0] pre_q;
         always_ff @(posedge clk) begin
            if (!rst_n || clr)
               pre_q <= '0;
            else if (run)
               pre_q <= (pre_q == PW'(CYC_PER_MS-1)) ? '0 : pre_q + 1'b1;
         end
         assign tick = run && (pre_q == PW'(CYC_PER_MS-1));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || clr)
         ms_q <= '0;
      else if (tick && (ms_q != '1))
         ms_q <= ms_q + 1'b1;
   end

   assign expired = ms_q > limit;
endmodule

// File: rtl/ners_pollchk.sv
module ners_pollchk (
   input  logic [7:0] prev,
   input  logic [7:0] cur,
   input  logic       older_b5,
   input  logic       full,
   output logic       ok,
   output logic       halt,
   output logic       dev
);
   assign ok   = full && cur[7];
   assign halt = full && !cur[7] && (cur == prev);
   assign dev  = older_b5;
endmodule

// File: rtl/nor_erase_seq.sv
module nor_erase_seq
   import ners_pkg::*;
#(
   parameter int SECT_LG     = 16,
   parameter int DEV_SECTORS = 32,
   parameter int CLK_HZ      = 50_000_000,
   parameter int WINDOW_US   = 50,
   parameter int BUDGET_MS   = 15000,
   parameter int VER_LG      = 7,
   localparam int DEV_BYTES  = DEV_SECTORS << SECT_LG,
   localparam int AW         = $clog2(DEV_BYTES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [AW-1:0] start_addr,
   input  logic [AW:0]   len_bytes,
   output logic          busy,
   output logic          done,
   output logic [2:0]    status,
   output logic          fl_req,
   output logic          fl_we,
   output logic [AW-1:0] fl_addr,
   output logic [7:0]    fl_wdata,
   input  logic [7:0]    fl_rdata
);
   localparam int     NSW        = AW + 1 - SECT_LG;
   localparam int     SS         = 1 << SECT_LG;
   localparam int     CYC_PER_MS = CLK_HZ / 1000;
   localparam int     MSW        = $clog2(DEV_SECTORS * BUDGET_MS + 1) + 1;
   localparam longint WIN_CYC    = longint'(CLK_HZ) * longint'(WINDOW_US) / 64'd1000000;

   generate
      if (SECT_LG < VER_LG || SECT_LG < 1) begin : g_bad_sect
         $error("sector size must be at least the verify sample count");
      end
      if (DEV_BYTES <= 32'h555) begin : g_bad_dev
         $error("device too small for the command addresses");
      end
      if (CYC_PER_MS < 1) begin : g_bad_clk
         $error("clock below 1 kHz");
      end
      if (WIN_CYC <= 3) begin : g_bad_win
         $error("acceptance window shorter than the sector command spacing");
      end
   endgenerate

   typedef enum logic [3:0] {
      S_IDLE, S_SETUP, S_CHIP, S_SCMD, S_SRD, S_SCAP,
      S_PRD, S_PCAP, S_VRD, S_VCAP
   } st_e;

   st_e            st_q;
   logic [2:0]     idx_q;
   logic [AW-1:0]  base_q, cur_q;
   logic [AW:0]    len_q, step_q, voff_q;
   logic [NSW-1:0] left_q;
   logic           chip_q;
   logic [MSW-1:0] lim_q;
   logic [7:0]     s_old_q, s_prev_q;
   logic [1:0]     nrd_q;
   logic           done_q;
   ers_stat_e      stat_q;

   logic arg_ok, arg_chip;
   logic p_ok, p_halt, p_dev;
   logic t_clr, t_run, t_exp;

   ners_argchk #(.AW(AW), .SECT_LG(SECT_LG), .DEV_BYTES(DEV_BYTES)) u_arg (
      .start(start_addr), .len(len_bytes), .ok(arg_ok), .chip(arg_chip));

   ners_pollchk u_poll (
      .prev(s_prev_q), .cur(fl_rdata), .older_b5(s_old_q[5]),
      .full(nrd_q == 2'd2), .ok(p_ok), .halt(p_halt), .dev(p_dev));

   assign t_clr = (st_q == S_CHIP) || (st_q == S_SCAP);
   assign t_run = (st_q == S_PRD) || (st_q == S_PCAP);

   ners_timer #(.CYC_PER_MS(CYC_PER_MS), .MSW(MSW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .clr(t_clr), .run(t_run),
      .limit(lim_q), .expired(t_exp));

   // Bus drive from the registered state
   always_comb begin
      fl_req   = 1'b0;
      fl_we    = 1'b0;
      fl_addr  = '0;
      fl_wdata = '0;
      case (st_q)
         S_SETUP: begin
            fl_req = 1'b1; fl_we = 1'b1;
            fl_addr = AW'(setup_addr(idx_q)); fl_wdata = setup_data(idx_q);
         end
         S_CHIP: begin
            fl_req = 1'b1; fl_we = 1'b1;
            fl_addr = AW'(CMD_ADDR); fl_wdata = CMD_CHIP;
         end
         S_SCMD: begin
            fl_req = 1'b1; fl_we = 1'b1;
            fl_addr = cur_q; fl_wdata = CMD_SECT;
         end
         S_SRD, S_PRD: begin
            fl_req = 1'b1; fl_addr = cur_q;
         end
         S_VRD: begin
            fl_req  = 1'b1;
            fl_addr = AW'({1'b0, base_q} + voff_q - (AW+1)'(1));
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= S_IDLE;
         idx_q    <= '0;
         base_q   <= '0;
         cur_q    <= '0;
         len_q    <= '0;
         step_q   <= '0;
         voff_q   <= '0;
         left_q   <= '0;
         chip_q   <= 1'b0;
         lim_q    <= '0;
         s_old_q  <= '0;
         s_prev_q <= '0;
         nrd_q    <= '0;
         done_q   <= 1'b0;
         stat_q   <= ES_OK;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            S_IDLE: if (go) begin
               if (!arg_ok) begin
                  done_q <= 1'b1;
                  stat_q <= ES_BADARG;
               end else begin
                  base_q <= start_addr;
                  len_q  <= len_bytes;
                  step_q <= len_bytes >> VER_LG;
                  chip_q <= arg_chip;
                  lim_q  <= MSW'(len_bytes[AW:SECT_LG]) * MSW'(BUDGET_MS);
                  idx_q  <= '0;
                  st_q   <= S_SETUP;
               end
            end
            S_SETUP: begin
               idx_q <= idx_q + 1'b1;
               if (idx_q == 3'(SETUP_LEN-1)) begin
                  st_q   <= chip_q ? S_CHIP : S_SCMD;
                  cur_q  <= base_q;
                  left_q <= len_q[AW:SECT_LG];
               end
            end
            S_CHIP: begin
               st_q   <= S_PRD;
               cur_q  <= '0;
               left_q <= NSW'(1);
               nrd_q  <= '0;
            end
            S_SCMD: st_q <= S_SRD;
            S_SRD:  st_q <= S_SCAP;
            S_SCAP: begin
               if (fl_rdata[3]) begin
                  done_q <= 1'b1; stat_q <= ES_WINDOW; st_q <= S_IDLE;
               end else if (left_q == NSW'(1)) begin
                  st_q   <= S_PRD;
                  cur_q  <= base_q;
                  left_q <= len_q[AW:SECT_LG];
                  nrd_q  <= '0;
               end else begin
                  cur_q  <= cur_q + AW'(SS);
                  left_q <= left_q - 1'b1;
                  st_q   <= S_SCMD;
               end
            end
            S_PRD: begin
               if (t_exp) begin
                  done_q <= 1'b1; stat_q <= ES_TIMEOUT; st_q <= S_IDLE;
               end else
                  st_q <= S_PCAP;
            end
            S_PCAP: begin
               s_old_q  <= s_prev_q;
               s_prev_q <= fl_rdata;
               if (nrd_q != 2'd2) nrd_q <= nrd_q + 1'b1;
               if (p_ok) begin
                  if (left_q == NSW'(1)) begin
                     st_q   <= S_VRD;
                     voff_q <= len_q;
                  end else begin
                     cur_q  <= cur_q + AW'(SS);
                     left_q <= left_q - 1'b1;
                     nrd_q  <= '0;
                     st_q   <= S_PRD;
                  end
               end else if (p_halt) begin
                  done_q <= 1'b1;
                  stat_q <= p_dev ? ES_DEVFAULT : ES_STALLED;
                  st_q   <= S_IDLE;
               end else if (t_exp) begin
                  done_q <= 1'b1; stat_q <= ES_TIMEOUT; st_q <= S_IDLE;
               end else
                  st_q <= S_PRD;
            end
            S_VRD: st_q <= S_VCAP;
            S_VCAP: begin
               if (fl_rdata != ERASED) begin
                  done_q <= 1'b1; stat_q <= ES_BADVERIFY; st_q <= S_IDLE;
               end else if (voff_q == step_q) begin
                  done_q <= 1'b1; stat_q <= ES_OK; st_q <= S_IDLE;
               end else begin
                  voff_q <= voff_q - step_q;
                  st_q   <= S_VRD;
               end
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   assign busy   = (st_q != S_IDLE);
   assign done   = done_q;
   assign status = stat_q;
endmodule

// File: rtl/ners_chk.sv
module ners_chk
   import ners_pkg::*;
#(
   parameter int AW        = 21,
   parameter int CLK_HZ    = 50_000_000,
   parameter int WINDOW_US = 50
) (
   input logic          clk,
   input logic          rst_n,
   input logic          go,
   input logic          busy,
   input logic          done,
   input logic [2:0]    status,
   input logic          fl_req,
   input logic          fl_we,
   input logic [AW-1:0] fl_addr,
   input logic [7:0]    fl_wdata,
   input logic [7:0]    fl_rdata
);
   localparam longint WIN_CYC = longint'(CLK_HZ) * longint'(WINDOW_US) / 64'd1000000;

   logic        sect_wr;
   logic [15:0] gap_q;
   logic        seen_q;

   assign sect_wr = fl_req && fl_we && (fl_wdata == CMD_SECT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap_q  <= '0;
         seen_q <= 1'b0;
      end else begin
         if (!busy)        seen_q <= 1'b0;
         else if (sect_wr) seen_q <= 1'b1;
         if (sect_wr)             gap_q <= 16'd1;
         else if (gap_q != '1)    gap_q <= gap_q + 1'b1;
      end
   end

   a_r1_badarg_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (done && status == 3'(ES_BADARG)) |-> ($past(go) && !$past(busy)));

   a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !fl_req);

   a_r2_first_write: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (fl_req && fl_we && fl_wdata == 8'hF0 && fl_addr == AW'(CMD_ADDR)));

   a_r3_chip_cmd_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_req && fl_we && fl_wdata == CMD_CHIP) |-> (fl_addr == AW'(CMD_ADDR)));

   a_r4_window_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (sect_wr && seen_q) |-> (64'(gap_q) < WIN_CYC));

   a_r5_window_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (done && status == 3'(ES_WINDOW)) |-> $past(fl_rdata[3]));

   a_r9_ok_after_ff: assert property (@(posedge clk) disable iff (!rst_n)
      (done && status == 3'(ES_OK)) |-> ($past(fl_rdata) == ERASED));

   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r10_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
endmodule

bind nor_erase_seq ners_chk #(.AW(AW), .CLK_HZ(CLK_HZ), .WINDOW_US(WINDOW_US)) u_chk (.*);

// File: tb/sim_nor_erase_seq.sv
module sim_nor_erase_seq;
   localparam int CLK_PER = 10;
   localparam int AW      = 11;
   localparam int BUSY_N  = 12;
   localparam int M_OK = 0, M_WIN = 1, M_SPIN = 2, M_HOT = 3, M_DEAD = 4;

   typedef struct packed { logic [10:0] a; logic [7:0] d; } wr_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          go = 1'b0;
   logic [AW-1:0] start_addr = '0;
   logic [AW:0]   len_bytes = '0;
   logic          busy, done;
   logic [2:0]    status;
   logic          fl_req, fl_we;
   logic [AW-1:0] fl_addr;
   logic [7:0]    fl_wdata;
   logic [7:0]    fl_rdata = '0;

   nor_erase_seq #(.SECT_LG(8), .DEV_SECTORS(8), .CLK_HZ(100_000),
                   .WINDOW_US(50), .BUDGET_MS(1), .VER_LG(7)) u0 (.*);

   always #(CLK_PER/2) clk = ~clk;

   int nchk = 0, nerr = 0, mchk = 0, merr = 0, dones = 0, cyc = 0;
   wr_t wq[$];

   // ---------------- flash model ----------------
   logic [7:0] mem [0:2047];
   logic [7:0] mark;
   int  mode = M_OK, bad_addr = -1, bcnt = 0;
   bit  init_req = 1'b0, erasing = 1'b0, tog = 1'b0;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (init_req) begin
         for (int i = 0; i < 2048; i++) mem[i] = 8'h00;
         mark = '0; erasing = 1'b0; tog = 1'b0;
      end else if (fl_req && fl_we) begin
         if (fl_wdata == 8'h10 && fl_addr == 11'h555) begin
            erasing = 1'b1; mark = '1; bcnt = BUSY_N;
         end else if (fl_wdata == 8'h30) begin
            erasing = 1'b1; mark[fl_addr[10:8]] = 1'b1; bcnt = BUSY_N;
         end
      end else if (fl_req) begin
         if (!erasing) fl_rdata <= mem[fl_addr];
         else begin
            case (mode)
               M_HOT:   fl_rdata <= 8'h20;
               M_DEAD:  fl_rdata <= 8'h00;
               default: fl_rdata <= {1'b0, tog, 2'b00, (mode == M_WIN), 3'b000};
            endcase
            tog = ~tog;
            if (mode == M_OK) begin
               bcnt--;
               if (bcnt == 0) begin
                  erasing = 1'b0;
                  for (int i = 0; i < 2048; i++)
                     if (mark[i >> 8] && i != bad_addr) mem[i] = 8'hFF;
               end
            end
         end
      end
   end

   // ---------------- monitor ----------------
   int last30 = -1;
   always @(negedge clk) begin
      if (done) dones++;
      if (!busy) last30 = -1;
      if (fl_req && fl_we) begin
         if (wq.size() == 0) begin
            mchk++; merr++;
            $display("FAIL R2 unexpected write: actual %h@%h expected none", fl_wdata, fl_addr);
         end else begin
            wr_t e;
            string tg;
            e = wq.pop_front();
            tg = (e.d == 8'h10) ? "R3" : ((e.d == 8'h30) ? "R4" : "R2");
            mchk++;
            if (fl_addr != e.a || fl_wdata != e.d) begin
               merr++;
               $display("FAIL %s bus write: actual %h@%h expected %h@%h", tg, fl_wdata, fl_addr, e.d, e.a);
            end
         end
         if (fl_wdata == 8'h30) begin
            if (last30 >= 0) begin
               mchk++;
               if (cyc - last30 > 3) begin
                  merr++;
                  $display("FAIL R4 sector command gap: actual %0d expected <= 3", cyc - last30);
               end
            end
            last30 = cyc;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic run(input int s, input int l, input int md, input int bad,
                      input int exp, input bit poke, input string req);
      bit valid, chip;
      int d0, n;
      valid = (s % 256 == 0) && (l % 256 == 0) && (l != 0) && (s + l <= 2048);
      chip  = valid && s == 0 && l == 2048;
      mode = md; bad_addr = bad;
      init_req = 1'b1; @(negedge clk); init_req = 1'b0;
      if (valid) begin
         for (int i = 0; i < 6; i++) begin
            logic [10:0] a; logic [7:0] d;
            a = (i == 2 || i == 5) ? 11'h2AA : 11'h555;
            d = (i == 0) ? 8'hF0 : (i == 3) ? 8'h80 : (i == 1 || i == 4) ? 8'hAA : 8'h55;
            wq.push_back('{a: a, d: d});
         end
         if (chip) wq.push_back('{a: 11'h555, d: 8'h10});
         else begin
            n = (exp == 2) ? 1 : l / 256;
            for (int k = 0; k < n; k++) wq.push_back('{a: 11'(s + k*256), d: 8'h30});
         end
      end
      d0 = dones;
      start_addr = AW'(s); len_bytes = (AW+1)'(l); go = 1'b1;
      @(negedge clk); go = 1'b0;
      if (!valid) chk(done == 1'b1, "R1", "done one cycle after rejected go", int'(done), 1);
      else begin
         chk(busy == 1'b1, "R10", "busy after accepted go", int'(busy), 1);
         if (poke) begin
            repeat (3) @(negedge clk);
            start_addr = '0; len_bytes = 12'd2048; go = 1'b1;
            @(negedge clk); go = 1'b0;
         end
         n = 0;
         while (!done && n < 20000) begin @(negedge clk); n++; end
      end
      chk(status == 3'(exp), req, "result status", int'(status), exp);
      @(negedge clk);
      chk(dones - d0 == 1, "R10", "done pulses per run", dones - d0, 1);
      chk(busy == 1'b0, "R10", "busy low after done", int'(busy), 0);
      chk(wq.size() == 0, "R2", "expected writes left over", wq.size(), 0);
      wq.delete();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      chk(busy == 1'b0, "R10", "reset busy", int'(busy), 0);
      chk(done == 1'b0, "R10", "reset done", int'(done), 0);
      chk(fl_req == 1'b0, "R2", "reset bus idle", int'(fl_req), 0);
      // R1: misaligned start, misaligned length, zero length, range past end
      run(5, 256, M_OK, -1, 1, 0, "R1");
      run(0, 100, M_OK, -1, 1, 0, "R1");
      run(256, 0, M_OK, -1, 1, 0, "R1");
      run(1792, 512, M_OK, -1, 1, 0, "R1");
      // R3: whole device
      run(0, 2048, M_OK, -1, 0, 0, "R3");
      chk(mem[2047] == 8'hFF && mem[0] == 8'hFF, "R3", "whole device erased", int'(mem[2047]), 255);
      // R6 / R10: two sectors, go poked while busy
      run(512, 512, M_OK, -1, 0, 1, "R6");
      // R4: partial range from address 0 and the last sector
      run(0, 768, M_OK, -1, 0, 0, "R4");
      chk(mem[768] == 8'h00, "R4", "sector outside range untouched", int'(mem[768]), 0);
      run(1792, 256, M_OK, -1, 0, 0, "R4");
      // R5: window closed
      run(512, 512, M_WIN, -1, 2, 0, "R5");
      // R8: never completes
      run(512, 512, M_SPIN, -1, 3, 0, "R8");
      // R7: stuck with and without bit 5
      run(512, 256, M_HOT, -1, 4, 0, "R7");
      run(512, 256, M_DEAD, -1, 5, 0, "R7");
      // R9: sampled byte k=5 bad, then unsampled byte bad
      run(512, 512, M_OK, 512 + 512 - 1 - 5*4, 6, 0, "R9");
      run(512, 512, M_OK, 514, 0, 0, "R9");
      $display("Simulation finished: %0d checks, %0d errors", nchk + mchk, nerr + merr);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      $display("FAIL watchdog: run did not end, actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", nchk + mchk + 1, nerr + merr + 1);
      $finish;
   end
endmodule